// File: doc/BRIEF.md
# Two-way set-associative address translation buffer

This block caches translations from 40-bit virtual addresses to 36-bit physical addresses for 16 KB pages. It holds 512 translations organised as 256 sets of two ways. A lookup presents a virtual address together with the access kind (read or write) and the privilege of the requester. In the same cycle the block reports one of three outcomes: a hit with the physical address, a protection fault, or a trap that hands the miss to privileged software. The block never walks a page table itself.

Software refills the buffer through a write port that names a set, a way and the full contents of an entry. Each entry also keeps a reference bit, which is set whenever the entry hits, and a dirty bit, which is set when a write hits it. Both bits are shown on every lookup, so software can choose victims and decide which pages need write-back. A single clear input wipes every reference bit at once.

Top module: `xlat_sa_top`

## Requirements
- R1: A synchronous active-low reset invalidates every entry, so any lookup that follows it traps.
- R2: Bits 21:14 of the virtual address select the set and bits 39:22 form the tag. On a hit the physical address is the entry's 22-bit frame number followed by virtual address bits 13:0, unchanged.
- R3: Lookup is combinational. Hit, fault, trap and physical address are valid in the same cycle as the request.
- R4: A request whose tag matches no valid entry in its set raises trap only, with hit and fault low. Exactly one outcome is raised per request.
- R5: Software installation through the write port takes effect at the next clock edge. A lookup in the following cycle sees the new entry, and the other way of that set is not disturbed.
- R6: The access field uses these codes: 00 means no access, 01 read-only, 10 read-write, 11 kernel-only. Any access to a 00 page faults. A write to a 01 page faults. A user access (user input 1) to an 11 page faults. Every other case hits. A fault gives a zero physical address.
- R7: A hit sets the entry's reference bit from the next cycle onward. The lookup outputs show the entry's reference and dirty bits as they stand before this access updates them.
- R8: A write hit sets the entry's dirty bit. A read hit leaves it unchanged.
- R9: One cycle of the reference-clear input clears the reference bit of every entry.
- R10: The two ways of a set hold different tags at the same time. The same tag in a different set does not match.
- R11: With no request, hit, fault, trap, the physical address and the shown bits are all zero, and no entry state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 40 | Virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user-mode requester |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Translation found but access denied |
| lk_trap | output | 1 | No translation; software refill needed |
| lk_pa | output | 36 | Physical address (zero unless hit) |
| lk_ref | output | 1 | Reference bit of matched entry before this access |
| lk_dirty | output | 1 | Dirty bit of matched entry before this access |
| wr_en | input | 1 | Install an entry |
| wr_set | input | 8 | Target set |
| wr_way | input | 1 | Target way |
| wr_valid | input | 1 | Valid bit to store |
| wr_dirty | input | 1 | Dirty bit to store |
| wr_acc | input | 2 | Access code to store |
| wr_tag | input | 18 | Tag to store |
| wr_ppn | input | 22 | Physical frame number to store |
| ref_clear | input | 1 | Clear all reference bits |

## Verification
The bench sets up a tag that appears in two different sets, and two tags that share one set. A design that swapped the index and tag bit ranges, or that compared only one way, would hit on the wrong entry or trap on a resident page. Each access code is tried with reads, writes, user requests and kernel requests, because a slip in the permission decode turns a fault into a hit. Reference and dirty bits are read back across consecutive cycles: an update that landed in the same cycle, landed on the wrong entry, or fired on reads would show in the second lookup. The bench also checks a lookup one cycle after an install, an idle request that must leave the reference bit clear, and a reset that must empty the buffer.

// File: rtl/xlat_pkg.sv
// Shared types for the translation buffer: the access-rights code and the
// layout of one stored entry. Assumes the 18-bit tag / 22-bit frame split
// of a 40-bit virtual and 36-bit physical space with 16 KB pages.
package xlat_pkg;
    localparam int TAG_W = 18;
    localparam int PPN_W = 22;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RO   = 2'b01,
        ACC_RW   = 2'b10,
        ACC_KERN = 2'b11
    } acc_e;

    typedef struct packed {
        logic             valid;
        logic             refd;
        logic             dirty;
        acc_e             acc;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } entry_t;
endpackage

// File: rtl/xlat_way.sv
// One way of the buffer: per-set storage for one entry, a combinational read
// port, a software write port, and hit-driven updates of the reference and
// dirty bits. Assumes at most one hit update and one write per cycle. When a
// write and a hit update target the same set, the write wins.
module xlat_way
    import xlat_pkg::*;
#(
    parameter int SETS  = 256,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output entry_t           rd_entry,
    input  logic             upd_en,
    input  logic             upd_dirty,
    input  logic [IDX_W-1:0] upd_set,
    input  logic             clr_ref,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_set,
    input  entry_t           wr_entry
);
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  ref_q;
    logic [SETS-1:0]  dirty_q;
    logic [1:0]       acc_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PPN_W-1:0] ppn_q [SETS];

    // Status bits: reset, bulk clear, hit update, then software overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
            dirty_q <= '0;
        end else begin
            if (clr_ref)
                ref_q <= '0;
            if (upd_en) begin
                ref_q[upd_set] <= 1'b1;
                if (upd_dirty)
                    dirty_q[upd_set] <= 1'b1;
            end
            if (wr_en) begin
                valid_q[wr_set] <= wr_entry.valid;
                ref_q[wr_set]   <= 1'b0;
                dirty_q[wr_set] <= wr_entry.dirty;
            end
        end
    end

    // Payload fields: written only by software, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            acc_q[wr_set] <= wr_entry.acc;
            tag_q[wr_set] <= wr_entry.tag;
            ppn_q[wr_set] <= wr_entry.ppn;
        end
    end

    // Read port: assemble the entry at the looked-up set.
    always_comb begin
        rd_entry.valid = valid_q[rd_set];
        rd_entry.refd  = ref_q[rd_set];
        rd_entry.dirty = dirty_q[rd_set];
        rd_entry.acc   = acc_e'(acc_q[rd_set]);
        rd_entry.tag   = tag_q[rd_set];
        rd_entry.ppn   = ppn_q[rd_set];
    end

    // R5: an install is visible at its set from the next cycle.
    p_install_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_set)] == $past(wr_entry.valid))
               && (tag_q[$past(wr_set)] == $past(wr_entry.tag)));

    // R8: a write hit leaves the entry dirty unless overwritten the same cycle.
    p_dirty_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_dirty && !(wr_en && wr_set == upd_set))
            |=> dirty_q[$past(upd_set)]);

    // R9: a bulk clear with no concurrent hit empties every reference bit.
    p_ref_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref && !upd_en) |=> (ref_q == '0));
endmodule

// File: rtl/xlat_cmp.sv
// Tag comparison and permission check for one way. Purely combinational.
// Assumes the entry presented is the one stored at the requested set.
module xlat_cmp
    import xlat_pkg::*;
(
    input  entry_t           ent,
    input  logic [TAG_W-1:0] tag,
    input  logic             is_write,
    input  logic             is_user,
    output logic             match,
    output logic             allow
);
    // Match: valid entry with an equal tag.
    always_comb match = ent.valid && (ent.tag == tag);

    // Permission decode from the access code, kind and privilege.
    always_comb begin
        unique case (ent.acc)
            ACC_NONE: allow = 1'b0;
            ACC_RO:   allow = !is_write;
            ACC_RW:   allow = 1'b1;
            ACC_KERN: allow = !is_user;
            default:  allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlat_sa_top.sv
// Two-way set-associative translation buffer. Combinational lookup returns
// hit, fault or trap in the request cycle. Misses are left to software,
// which installs entries through the write port. Assumes software does not
// install the same tag in both ways of one set; if it does, way 0 wins.
module xlat_sa_top
    import xlat_pkg::*;
#(
    parameter int VA_W  = 40,
    parameter int PA_W  = 36,
    parameter int OFF_W = 14,
    parameter int SETS  = 256,
    parameter int WAYS  = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int VTAG_W = VA_W - OFF_W - IDX_W,
    localparam int FRM_W  = PA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic              lk_trap,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_ref,
    output logic              lk_dirty,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [1:0]        wr_acc,
    input  logic [VTAG_W-1:0] wr_tag,
    input  logic [FRM_W-1:0]  wr_ppn,
    input  logic              ref_clear
);
    logic [IDX_W-1:0]  set_idx;
    logic [VTAG_W-1:0] va_tag;
    entry_t            way_ent   [WAYS];
    logic [WAYS-1:0]   way_match;
    logic [WAYS-1:0]   way_allow;
    entry_t            new_ent;
    logic              found;
    logic              sel_allow;
    logic [WAY_W-1:0]  sel_way;
    entry_t            sel_ent;

    // Address split: set index above the page offset, tag above that.
    always_comb begin
        set_idx = lk_va[OFF_W +: IDX_W];
        va_tag  = lk_va[VA_W-1 -: VTAG_W];
    end

    // Entry image presented by the write port.
    always_comb begin
        new_ent.valid = wr_valid;
        new_ent.refd  = 1'b0;
        new_ent.dirty = wr_dirty;
        new_ent.acc   = acc_e'(wr_acc);
        new_ent.tag   = wr_tag;
        new_ent.ppn   = wr_ppn;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic w_upd;
        logic w_wr;

        // Per-way strobes: hit update and software write for this way only.
        always_comb begin
            w_upd = lk_hit && (sel_way == WAY_W'(w));
            w_wr  = wr_en && (wr_way == WAY_W'(w));
        end

        xlat_way #(.SETS(SETS)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_set    (set_idx),
            .rd_entry  (way_ent[w]),
            .upd_en    (w_upd),
            .upd_dirty (lk_write),
            .upd_set   (set_idx),
            .clr_ref   (ref_clear),
            .wr_en     (w_wr),
            .wr_set    (wr_set),
            .wr_entry  (new_ent)
        );

        xlat_cmp u_cmp (
            .ent      (way_ent[w]),
            .tag      (va_tag),
            .is_write (lk_write),
            .is_user  (lk_user),
            .match    (way_match[w]),
            .allow    (way_allow[w])
        );
    end

    // Way select: the lowest-numbered matching way wins.
    always_comb begin
        found     = 1'b0;
        sel_allow = 1'b0;
        sel_way   = '0;
        sel_ent   = way_ent[0];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                found     = 1'b1;
                sel_allow = way_allow[w];
                sel_way   = WAY_W'(w);
                sel_ent   = way_ent[w];
            end
        end
    end

    // Outcome and result: exactly one flag per request, data only on hit.
    always_comb begin
        lk_hit   = lk_req && found && sel_allow;
        lk_fault = lk_req && found && !sel_allow;
        lk_trap  = lk_req && !found;
        lk_pa    = lk_hit ? {sel_ent.ppn, lk_va[OFF_W-1:0]} : '0;
        lk_ref   = lk_req && found && sel_ent.refd;
        lk_dirty = lk_req && found && sel_ent.dirty;
    end

    // R4: every request yields exactly one outcome.
    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> ($countones({lk_hit, lk_fault, lk_trap}) == 1));

    // R11: without a request nothing is reported.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> ({lk_hit, lk_fault, lk_trap, lk_ref, lk_dirty} == '0) && (lk_pa == '0));

    // R2: a hit keeps the page offset untouched.
    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

    // R6: a write to a read-only page never hits.
    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && found && sel_ent.acc == ACC_RO && lk_write) |-> lk_fault);

    // R1: the cycle after reset every lookup traps.
    p_reset_empty_r1: assert property (@(posedge clk)
        (!rst_n ##1 lk_req) |-> lk_trap);
endmodule

// File: tb/tb_xlat_sa_top.sv
module tb_xlat_sa_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req, lk_write, lk_user;
    logic [39:0] lk_va;
    logic        lk_hit, lk_fault, lk_trap, lk_ref, lk_dirty;
    logic [35:0] lk_pa;
    logic        wr_en, wr_way, wr_valid, wr_dirty, ref_clear;
    logic [7:0]  wr_set;
    logic [1:0]  wr_acc;
    logic [17:0] wr_tag;
    logic [21:0] wr_ppn;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xlat_sa_top dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
        .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit),
        .lk_fault(lk_fault), .lk_trap(lk_trap), .lk_pa(lk_pa),
        .lk_ref(lk_ref), .lk_dirty(lk_dirty), .wr_en(wr_en),
        .wr_set(wr_set), .wr_way(wr_way), .wr_valid(wr_valid),
        .wr_dirty(wr_dirty), .wr_acc(wr_acc), .wr_tag(wr_tag),
        .wr_ppn(wr_ppn), .ref_clear(ref_clear)
    );

    // Row: tag, set, offset, write, user, exp hit, exp fault, exp trap, exp frame
    localparam int NV = 10;
    localparam logic [66:0] TBL [NV] = '{
        {18'h12345, 8'h05, 14'h0123, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 22'h0ABCD},
        {18'h12345, 8'h05, 14'h3FFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 22'h0ABCD},
        {18'h00001, 8'h05, 14'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 22'h11111},
        {18'h00001, 8'h05, 14'h0010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 22'h00000},
        {18'h3FFFF, 8'hFF, 14'h2AAA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 22'h3FFFFF},
        {18'h3FFFF, 8'hFF, 14'h2AAA, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 22'h00000},
        {18'h12345, 8'h00, 14'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 22'h00000},
        {18'h12345, 8'h06, 14'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 22'h00000},
        {18'h00002, 8'h05, 14'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 22'h00000},
        {18'h3FFFF, 8'hFF, 14'h1555, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 22'h3FFFFF}
    };

    task automatic chk(input bit ok, input string lbl, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
        end
    endtask

    task automatic install(input logic [7:0] s, input logic w, input logic [1:0] a,
                           input logic [17:0] t, input logic [21:0] p);
        wr_en = 1'b1; wr_set = s; wr_way = w; wr_valid = 1'b1; wr_dirty = 1'b0;
        wr_acc = a; wr_tag = t; wr_ppn = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [17:0] t, input logic [7:0] s, input logic [13:0] o,
                        input logic w, input logic u);
        lk_req = 1'b1; lk_va = {t, s, o}; lk_write = w; lk_user = u;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; lk_req = 1'b0; lk_va = '0; lk_write = 1'b0; lk_user = 1'b0;
        wr_en = 1'b0; wr_set = '0; wr_way = 1'b0; wr_valid = 1'b0; wr_dirty = 1'b0;
        wr_acc = '0; wr_tag = '0; wr_ppn = '0; ref_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(18'h12345, 8'h05, 14'h0, 1'b0, 1'b0);
        chk(lk_trap && !lk_hit && !lk_fault, "R1 trap after reset", {lk_hit, lk_fault, lk_trap}, 3'b001);
        // R11: idle outputs
        lk_req = 1'b0; #1;
        chk({lk_hit, lk_fault, lk_trap, lk_ref, lk_dirty} == 0 && lk_pa == 0, "R11 idle outputs zero",
            {lk_hit, lk_fault, lk_trap, lk_pa}, 0);
        @(negedge clk);

        install(8'h05, 1'b0, 2'b10, 18'h12345, 22'h0ABCD);
        install(8'h05, 1'b1, 2'b01, 18'h00001, 22'h11111);
        install(8'hFF, 1'b0, 2'b11, 18'h3FFFF, 22'h3FFFFF);
        install(8'h00, 1'b1, 2'b00, 18'h12345, 22'h00002);

        // R2 R3 R4 R6 R10: table walk, checked in the request cycle
        for (int i = 0; i < NV; i++) begin
            logic [66:0] v;
            logic [35:0] epa;
            v = TBL[i];
            look(v[66:49], v[48:41], v[40:27], v[26], v[25]);
            epa = v[24] ? {v[21:0], v[40:27]} : 36'h0;
            chk({lk_hit, lk_fault, lk_trap} == v[24:22], $sformatf("R4 R6 R10 row %0d outcome", i),
                {lk_hit, lk_fault, lk_trap}, v[24:22]);
            chk(lk_pa == epa, $sformatf("R2 R3 row %0d address", i), lk_pa, epa);
            @(negedge clk);
        end

        // R5: install then look up next cycle
        install(8'h40, 1'b0, 2'b10, 18'h00AAA, 22'h00100);
        install(8'h40, 1'b1, 2'b10, 18'h00BBB, 22'h00200);
        look(18'h00BBB, 8'h40, 14'h0042, 1'b0, 1'b1);
        chk(lk_hit && lk_pa == {22'h00200, 14'h0042}, "R5 hit right after install", lk_pa, {22'h00200, 14'h0042});
        lk_req = 1'b0;
        install(8'h40, 1'b1, 2'b10, 18'h00CCC, 22'h00300);
        look(18'h00BBB, 8'h40, 14'h0, 1'b0, 1'b1);
        chk(lk_trap, "R5 replaced tag traps", lk_trap, 1);
        @(negedge clk);
        look(18'h00CCC, 8'h40, 14'h0, 1'b0, 1'b1);
        chk(lk_hit && lk_pa[35:14] == 22'h00300, "R5 new tag hits", lk_pa[35:14], 22'h00300);
        @(negedge clk);
        look(18'h00AAA, 8'h40, 14'h0, 1'b0, 1'b1);
        chk(lk_hit && lk_pa[35:14] == 22'h00100, "R10 other way kept", lk_pa[35:14], 22'h00100);
        @(negedge clk);

        // R7 R8: reference and dirty bits across cycles
        lk_req = 1'b0;
        install(8'h41, 1'b0, 2'b10, 18'h00111, 22'h00400);
        look(18'h00111, 8'h41, 14'h0, 1'b0, 1'b1);
        chk(!lk_ref && !lk_dirty, "R7 fresh entry unreferenced", {lk_ref, lk_dirty}, 0);
        @(negedge clk); #1;
        chk(lk_ref, "R7 reference set after hit", lk_ref, 1);
        chk(!lk_dirty, "R8 read hit leaves clean", lk_dirty, 0);
        @(negedge clk);
        look(18'h00111, 8'h41, 14'h0, 1'b1, 1'b1);
        chk(!lk_dirty, "R7 dirty shown before update", lk_dirty, 0);
        @(negedge clk); #1;
        chk(lk_dirty, "R8 write hit sets dirty", lk_dirty, 1);
        @(negedge clk);

        // R9: bulk clear of reference bits
        lk_req = 1'b0; ref_clear = 1'b1;
        @(negedge clk);
        ref_clear = 1'b0;
        look(18'h00111, 8'h41, 14'h0, 1'b0, 1'b1);
        chk(lk_hit && !lk_ref, "R9 reference cleared", lk_ref, 0);
        @(negedge clk);
        look(18'h00AAA, 8'h40, 14'h0, 1'b0, 1'b1);
        chk(lk_hit && !lk_ref, "R9 other entry cleared", lk_ref, 0);
        lk_req = 1'b0;
        @(negedge clk);

        // R11: idle request leaves state alone
        ref_clear = 1'b1;
        @(negedge clk);
        ref_clear = 1'b0;
        lk_req = 1'b0; lk_va = {18'h00111, 8'h41, 14'h0};
        #1;
        chk({lk_hit, lk_fault, lk_trap} == 0, "R11 no request no outcome", {lk_hit, lk_fault, lk_trap}, 0);
        @(negedge clk);
        look(18'h00111, 8'h41, 14'h0, 1'b0, 1'b1);
        chk(!lk_ref, "R11 idle did not reference", lk_ref, 0);
        lk_req = 1'b0;
        @(negedge clk);

        // R1: reset again empties the buffer
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(18'h00111, 8'h41, 14'h0, 1'b0, 1'b1);
        chk(lk_trap && !lk_hit, "R1 reset invalidates", {lk_hit, lk_trap}, 2'b01);
        lk_req = 1'b0;
        @(negedge clk);

        finish_run();
    end
endmodule